// File: doc/BRIEF.md
# Write-Guarded Seconds Clock Register Window

This block holds a 32-bit count of elapsed seconds and exposes it through a small register window on a simple bus. The bus carries an address offset, a write strobe and 16-bit write data, and returns 16-bit read data. A one-cycle tick input marks each second, and the count advances by one on each tick. The count holds seconds since 00:00 on 1 January 1950. It has no time-zone or daylight-saving adjustment.

Software cannot write the count at will. It first sets a guard bit. While that bit is set, the low half may be written any number of times. A write to the high half completes the sequence and clears the guard on its own. At reset the count takes a preset value supplied on an input pin, and the guard clears.

Top module: `secClockRegs`

## Requirements
- R1: After reset the count equals `presetValue`, and the guard bit is clear.
- R2: A read at offset 0x0 returns count bits 31:16. A read at offset 0x4 returns count bits 15:0.
- R3: A read at offset 0x8 always returns zero, whether the guard is set or clear.
- R4: While the guard is clear, writes to offset 0x0 or 0x4 leave the count unchanged.
- R5: While the guard is set, a write to offset 0x0 places the write data in count bits 31:16 and leaves bits 15:0 unchanged. The same write clears the guard, so a later half write is ignored.
- R6: While the guard is set, a write to offset 0x4 places the write data in count bits 15:0 and leaves bits 31:16 unchanged. The guard stays set.
- R7: Each cycle with `secTick` high and no accepted half write adds one to the count. The carry passes from the low half to the high half, and the count wraps from 0xFFFFFFFF to 0.
- R8: When an accepted half write and a tick occur in the same cycle, the write is applied and the increment is dropped.
- R9: Reads at offsets other than 0x0, 0x4 and 0x8 return zero. Writes at those offsets change neither the count nor the guard.
- R10: A write to offset 0x8 sets the guard to bit 0 of the write data, so writing 0 disarms it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 4 | Register byte offset |
| regWrite | input | 1 | Write strobe for the current offset |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data for the current offset, combinational |
| secTick | input | 1 | One-cycle pulse per second |
| presetValue | input | 32 | Count loaded while reset is asserted |

## Verification
The hardest case to reach from the ports is an armed half write that lands in the same cycle as a tick. The bench handles it by raising the tick together with the write strobe. It then reads both halves to confirm that no increment leaked in. The bench also covers a carry across the halves. It arms the guard, writes 0xFFFF into the low half and then ticks. A second case drives the count to 0xFFFFFFFE through the guarded sequence and ticks twice to show the wrap. The guard cannot be read back, because offset 0x8 reads as zero. So each guard change is inferred from whether a following half write takes effect.

// File: rtl/secClkPkg.sv
package secClkPkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_HI   = 2'd1,
    SEL_LO   = 2'd2
  } rdSel_e;

  typedef struct packed {
    logic   loadHi;
    logic   loadLo;
    logic   inc;
    rdSel_e rdSel;
  } cntCtl_t;
endpackage

// File: rtl/secClkCtrl.sv
module secClkCtrl
  import secClkPkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrite,
  input  logic              wrBit0,
  input  logic              secTick,
  output cntCtl_t           ctl
);
  localparam logic [ADDR_W-1:0] OFF_HI = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_LO = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_EN = ADDR_W'(8);

  logic hitHi, hitLo, hitEn;
  logic armed;

  assign hitHi = (regAddr == OFF_HI);
  assign hitLo = (regAddr == OFF_LO);
  assign hitEn = (regAddr == OFF_EN);

  // Guard bit: set or cleared through offset 0x8, and closed by an accepted high-half write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else if (regWrite && hitEn) begin
      armed <= wrBit0;
    end else if (regWrite && hitHi && armed) begin
      armed <= 1'b0;
    end
  end

  always_comb begin
    ctl.loadHi = regWrite && hitHi && armed;
    ctl.loadLo = regWrite && hitLo && armed;
    ctl.inc    = secTick && !(ctl.loadHi || ctl.loadLo);
    if (hitHi)      ctl.rdSel = SEL_HI;
    else if (hitLo) ctl.rdSel = SEL_LO;
    else            ctl.rdSel = SEL_NONE;
  end

  // R5: an accepted high-half write closes the window
  a_r5_window_closes: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && hitHi && armed) |=> !armed);

  // R6: a low-half write leaves the window open
  a_r6_window_stays: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && hitLo && armed) |=> armed);

  // R9: writes at unmapped offsets leave the guard as it was
  a_r9_guard_untouched: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && !hitHi && !hitLo && !hitEn) |=> $stable(armed));
endmodule

// File: rtl/secClkCount.sv
module secClkCount
  import secClkPkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  cntCtl_t             ctl,
  input  logic [HALF_W-1:0]   wrData,
  input  logic [2*HALF_W-1:0] presetValue,
  output logic [HALF_W-1:0]   rdData
);
  localparam int CNT_W = 2 * HALF_W;

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= presetValue;
    end else if (ctl.loadHi) begin
      count[CNT_W-1:HALF_W] <= wrData;
    end else if (ctl.loadLo) begin
      count[HALF_W-1:0] <= wrData;
    end else if (ctl.inc) begin
      count <= count + CNT_W'(1);
    end
  end

  always_comb begin
    unique case (ctl.rdSel)
      SEL_HI:  rdData = count[CNT_W-1:HALF_W];
      SEL_LO:  rdData = count[HALF_W-1:0];
      default: rdData = '0;
    endcase
  end

  // R7: a tick with no accepted write advances the count by one, wrapping
  a_r7_tick_step: assert property (@(posedge clk) disable iff (!rstN)
    ctl.inc |=> count == $past(count) + CNT_W'(1));

  // R5: a high-half load replaces only the upper half
  a_r5_hi_load: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadHi |=> (count[CNT_W-1:HALF_W] == $past(wrData))
                   && (count[HALF_W-1:0] == $past(count[HALF_W-1:0])));

  // R6: a low-half load replaces only the lower half
  a_r6_lo_load: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadLo |=> (count[HALF_W-1:0] == $past(wrData))
                   && (count[CNT_W-1:HALF_W] == $past(count[CNT_W-1:HALF_W])));

  // R4: with no strobe the count holds
  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.loadHi || ctl.loadLo || ctl.inc) |=> $stable(count));
endmodule

// File: rtl/secClockRegs.sv
module secClockRegs
  import secClkPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWrite,
  input  logic [HALF_W-1:0]   regWdata,
  output logic [HALF_W-1:0]   regRdata,
  input  logic                secTick,
  input  logic [2*HALF_W-1:0] presetValue
);
  cntCtl_t ctl;

  secClkCtrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWrite (regWrite),
    .wrBit0   (regWdata[0]),
    .secTick  (secTick),
    .ctl      (ctl)
  );

  secClkCount #(.HALF_W(HALF_W)) uCount (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .wrData      (regWdata),
    .presetValue (presetValue),
    .rdData      (regRdata)
  );
endmodule

// File: tb/secClockRegs_test.sv
module secClockRegs_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWrite = 1'b0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        secTick = 1'b0;
  logic [31:0] presetValue = 32'h8C3A_1F05;

  secClockRegs uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrite(regWrite),
    .regWdata(regWdata), .regRdata(regRdata), .secTick(secTick),
    .presetValue(presetValue)
  );

  always #4 clk = ~clk;

  typedef struct {
    logic [15:0] exp;
    logic [3:0]  addr;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] modelCnt;
  bit modelArm;

  // Monitor: compare each pending read away from the active edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      checks++;
      if (regRdata !== it.exp) begin
        errors++;
        $display("FAIL %s: addr 0x%0h actual 0x%04h expected 0x%04h",
                 it.tag, it.addr, regRdata, it.exp);
      end
    end
  end

  task automatic expectRead(input logic [3:0] a, input logic [15:0] e, input string tag);
    expItem_t it;
    @(posedge clk); #1;
    regAddr = a; regWrite = 1'b0;
    it.exp = e; it.addr = a; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic expectCount(input string tag);
    expectRead(4'h0, modelCnt[31:16], tag);
    expectRead(4'h4, modelCnt[15:0], tag);
  endtask

  task automatic doWrite(input logic [3:0] a, input logic [15:0] d, input bit t);
    bit loaded;
    @(posedge clk); #1;
    regAddr = a; regWdata = d; regWrite = 1'b1; secTick = t;
    @(posedge clk);
    loaded = 1'b0;
    if (a == 4'h8) modelArm = d[0];
    else if (a == 4'h0 && modelArm) begin
      modelCnt[31:16] = d; modelArm = 1'b0; loaded = 1'b1;
    end else if (a == 4'h4 && modelArm) begin
      modelCnt[15:0] = d; loaded = 1'b1;
    end
    if (t && !loaded) modelCnt = modelCnt + 32'd1;
    #1; regWrite = 1'b0; secTick = 1'b0;
  endtask

  task automatic doTick(input int n);
    @(posedge clk); #1;
    secTick = 1'b1;
    repeat (n) @(posedge clk);
    modelCnt = modelCnt + 32'(n);
    #1; secTick = 1'b0;
  endtask

  initial begin
    modelCnt = presetValue;
    modelArm = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    expectCount("R1 reset preset");                // R1, R2
    expectRead(4'h8, 16'h0, "R3 guard clear reads zero");

    doWrite(4'h0, 16'h1234, 1'b0);                // R4 and R1: guard starts clear
    doWrite(4'h4, 16'h5678, 1'b0);
    expectCount("R4 unarmed writes ignored");

    expectRead(4'hC, 16'h0, "R9 unmapped read 0xC");
    expectRead(4'h2, 16'h0, "R9 unmapped read 0x2");
    doWrite(4'hC, 16'h0001, 1'b0);                // R9: must not arm
    doWrite(4'h0, 16'h4321, 1'b0);
    expectCount("R9 unmapped write no effect");

    doWrite(4'h8, 16'h0001, 1'b0);
    expectRead(4'h8, 16'h0, "R3 guard set reads zero");
    doWrite(4'h4, 16'hAAAA, 1'b0);
    expectCount("R6 low write");
    doWrite(4'h4, 16'hFFFE, 1'b0);
    expectCount("R6 guard still open");
    doWrite(4'h0, 16'hFFFF, 1'b0);
    expectCount("R5 high write");
    doWrite(4'h0, 16'h1111, 1'b0);
    doWrite(4'h4, 16'h2222, 1'b0);
    expectCount("R5 window closed");

    doTick(1);
    expectCount("R7 tick to all ones");
    doTick(1);
    expectCount("R7 wrap to zero");
    doTick(3);
    expectCount("R7 three ticks");

    doWrite(4'h8, 16'h0001, 1'b0);
    doWrite(4'h8, 16'h0000, 1'b0);
    doWrite(4'h4, 16'h9999, 1'b0);
    expectCount("R10 disarm blocks write");

    doWrite(4'h8, 16'h0001, 1'b0);
    doWrite(4'h4, 16'h5555, 1'b1);
    expectCount("R8 low write beats tick");
    doWrite(4'h0, 16'h7777, 1'b1);
    expectCount("R8 high write beats tick");

    doWrite(4'h8, 16'h0001, 1'b0);
    doWrite(4'h4, 16'hFFFF, 1'b0);
    doTick(1);
    expectCount("R7 carry into high half");
    doWrite(4'h8, 16'h0001, 1'b1);                // tick on a guard write still counts
    expectCount("R7 tick during guard write");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule